// File: doc/BRIEF.md
# Two-Channel Serial Controller Register File with Loopback

This block is the register side of a two-channel serial controller as a processor sees it on an 8-bit I/O bus. Each channel has one data port and one control port. Every access takes one clock cycle and is marked by a read strobe or a write strobe. A write to a data port places the byte in a one-byte holding register. A later read of that data port returns the byte, so the channel behaves as a loopback. If a byte arrives while the previous one has not yet been read, a sticky overrun flag is raised.

A control port reaches one of eight control registers. The register is chosen by a pointer held in the low three bits of control register 0, and the pointer falls back to zero after each access. Reads through the control port return status bytes. Channel 1 also owns a shared interrupt vector register. Line transmission, baud generation and modem pins are not part of the block.

Top module: `sio_regfile`

## Requirements
- R1: Only addresses 0xFC to 0xFF are decoded. Address bit 0 selects the port: 0 is the data port and 1 is the control port. Address bit 1 selects the channel: 0xFC/0xFD are channel 0 and 0xFE/0xFF are channel 1. The two channels hold independent state.
- R2: The control pointer is bits [2:0] of control register 0. A control write that arrives while the pointer is 0 stores the whole byte in register 0, so its low three bits become the new pointer. Any other control write, and every control read, leaves the pointer at 0.
- R3: A control write with pointer 2 on channel 1 also loads the shared vector register. A control read with pointer 2 returns the vector on channel 1 and 0x00 on channel 0.
- R4: A control read with pointer 0 returns status 0. Its bits are: bit 5 = bit 1 of control register 5, bit 3 = bit 7 of control register 5, bit 2 = no byte held, bit 0 = byte held. All other bits are 0.
- R5: A control read with pointer 1 returns status 1. Its bit 5 is the overrun flag, which is set by a data write that arrives while a byte is still held. All other bits of status 1 are 0.
- R6: The overrun flag stays set until a control write with pointer 1 on the same channel, or until reset.
- R7: A data write stores the byte and marks it held. A data read returns the held byte and clears the held mark. A data read with nothing held returns 0x00.
- R8: Reset (active low, asynchronous) clears all control registers, held marks, overrun flags and the vector register.
- R9: rdata is 0x00 in every cycle without a read strobe. It is also 0x00 for reads outside 0xFC-0xFF and for control reads with pointer 3 to 7. Writes outside 0xFC-0xFF change nothing.
- R10: When rd_en and wr_en are both high, only the write is performed, and rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe for the current cycle |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | 8 | I/O address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational for the current cycle |

## Verification
The hardest state to reach from the ports is a control access to a register other than 0. It needs two accesses in sequence: a write that sets the pointer, then the access itself. Any stray control access in between silently sends the pointer back to 0. The overrun path is similar, because two data writes must come with no data read between them, and the flag then has to outlive further data traffic. The stimulus builds these sequences on purpose: a pointer write, the targeted access, an overrun pair, and later reads through pointer 1. A long random phase then mixes every port and strobe combination, and a behavioural model checks rdata in every cycle.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DW     = 8;
  localparam int NCH    = 2;
  localparam int NREG   = 8;
  localparam int PTR_W  = $clog2(NREG);

  localparam int PTR_STAT0 = 0;
  localparam int PTR_STAT1 = 1;
  localparam int PTR_VEC   = 2;
  localparam int REG_LINE  = 5;
  localparam int REG_OVRCL = 1;

  localparam int ST0_LINE1_BIT = 5;
  localparam int ST0_LINE7_BIT = 3;
  localparam int ST0_EMPTY_BIT = 2;
  localparam int ST0_FULL_BIT  = 0;
  localparam int ST1_OVR_BIT   = 5;

  // Status byte 0 built from line register and held flag
  function automatic logic [DW-1:0] mk_status0(input logic [DW-1:0] line_reg,
                                               input logic held);
    logic [DW-1:0] s;
    s = '0;
    s[ST0_LINE1_BIT] = line_reg[1];
    s[ST0_LINE7_BIT] = line_reg[7];
    s[ST0_EMPTY_BIT] = ~held;
    s[ST0_FULL_BIT]  = held;
    return s;
  endfunction

  // Status byte 1 built from overrun flag
  function automatic logic [DW-1:0] mk_status1(input logic ovr);
    logic [DW-1:0] s;
    s = '0;
    s[ST1_OVR_BIT] = ovr;
    return s;
  endfunction

  // Pointer after a control access
  function automatic logic [PTR_W-1:0] ptr_after(input logic [PTR_W-1:0] cur,
                                                 input logic is_wr,
                                                 input logic [PTR_W-1:0] wlow);
    return (is_wr && cur == '0) ? wlow : '0;
  endfunction
endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec
  import sio_pkg::*;
#(
  parameter logic [7:0] BASE = 8'hFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [7:0]      addr,
  output logic [NCH-1:0]  data_wr,
  output logic [NCH-1:0]  data_rd,
  output logic [NCH-1:0]  ctl_wr,
  output logic [NCH-1:0]  ctl_rd
);
  localparam int HI_W = 6;

  logic hit;
  logic rd_eff;
  logic is_ctl;
  logic chan;

  assign hit    = (addr[7:2] == BASE[7:2]);
  assign rd_eff = rd_en & ~wr_en;
  assign is_ctl = addr[0];
  assign chan   = addr[1];

  always_comb begin
    data_wr = '0;
    data_rd = '0;
    ctl_wr  = '0;
    ctl_rd  = '0;
    if (hit) begin
      if (is_ctl) begin
        ctl_wr[chan] = wr_en;
        ctl_rd[chan] = rd_eff;
      end else begin
        data_wr[chan] = wr_en;
        data_rd[chan] = rd_eff;
      end
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_wr, data_rd, ctl_wr, ctl_rd})); // R1
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[7:2] != BASE[7:2]) |-> ({data_wr, data_rd, ctl_wr, ctl_rd} == '0)); // R9
endmodule

// File: rtl/sio_chan.sv
module sio_chan
  import sio_pkg::*;
#(
  parameter bit HAS_VEC = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           data_wr,
  input  logic           data_rd,
  input  logic           ctl_wr,
  input  logic           ctl_rd,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  vec_in,
  output logic [DW-1:0]  rd_byte,
  output logic           vec_load
);
  logic [DW-1:0]    creg [NREG];
  logic [DW-1:0]    hold_q;
  logic             held_q;
  logic             ovr_q;
  logic [PTR_W-1:0] ptr;

  // Named internal events
  logic ovr_set_evt;
  logic ovr_clr_evt;
  logic ptr_load_evt;

  assign ptr          = creg[0][PTR_W-1:0];
  assign ovr_set_evt  = data_wr & held_q;
  assign ovr_clr_evt  = ctl_wr & (ptr == PTR_W'(REG_OVRCL));
  assign ptr_load_evt = ctl_wr & (ptr == '0);
  assign vec_load     = HAS_VEC & ctl_wr & (ptr == PTR_W'(PTR_VEC));

  // Control register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) creg[i] <= '0;
    end else if (ctl_wr) begin
      if (ptr == '0) begin
        creg[0] <= wdata;
      end else begin
        creg[ptr] <= wdata;
        creg[0][PTR_W-1:0] <= ptr_after(ptr, 1'b1, wdata[PTR_W-1:0]);
      end
    end else if (ctl_rd) begin
      creg[0][PTR_W-1:0] <= ptr_after(ptr, 1'b0, wdata[PTR_W-1:0]);
    end
  end

  // Loopback holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      held_q <= 1'b0;
    end else if (data_wr) begin
      hold_q <= wdata;
      held_q <= 1'b1;
    end else if (data_rd) begin
      held_q <= 1'b0;
    end
  end

  // Sticky overrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovr_q <= 1'b0;
    else if (ovr_set_evt) ovr_q <= 1'b1;
    else if (ovr_clr_evt) ovr_q <= 1'b0;
  end

  // Read mux
  always_comb begin
    rd_byte = '0;
    if (data_rd) begin
      rd_byte = held_q ? hold_q : '0;
    end else if (ctl_rd) begin
      case (ptr)
        PTR_W'(PTR_STAT0): rd_byte = mk_status0(creg[REG_LINE], held_q);
        PTR_W'(PTR_STAT1): rd_byte = mk_status1(ovr_q);
        PTR_W'(PTR_VEC):   rd_byte = HAS_VEC ? vec_in : '0;
        default:           rd_byte = '0;
      endcase
    end
  end

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd || (ctl_wr && ptr != '0)) |=> (ptr == '0)); // R2
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load_evt |=> (ptr == $past(wdata[PTR_W-1:0]))); // R2
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set_evt |=> ovr_q); // R5
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr_evt) |=> ovr_q); // R6
  AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr_evt && !ovr_set_evt) |=> !ovr_q); // R6
  AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (held_q && hold_q == $past(wdata))); // R7
  AST_DATA_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> !held_q); // R7
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !held_q) |-> (rd_byte == '0)); // R7
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int VEC_CH = 1;

  logic [NCH-1:0] data_wr, data_rd, ctl_wr, ctl_rd;
  logic [NCH-1:0] vec_load;
  logic [DW-1:0]  ch_byte [NCH];
  logic [DW-1:0]  vec_q;
  logic           vec_evt;

  sio_addr_dec #(.BASE(8'hFC)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .data_wr (data_wr),
    .data_rd (data_rd),
    .ctl_wr  (ctl_wr),
    .ctl_rd  (ctl_rd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sio_chan #(.HAS_VEC(c == VEC_CH)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (data_wr[c]),
      .data_rd  (data_rd[c]),
      .ctl_wr   (ctl_wr[c]),
      .ctl_rd   (ctl_rd[c]),
      .wdata    (wdata),
      .vec_in   (vec_q),
      .rd_byte  (ch_byte[c]),
      .vec_load (vec_load[c])
    );
  end

  assign vec_evt = |vec_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vec_q <= '0;
    else if (vec_evt) vec_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCH; c++) rdata |= ch_byte[c];
  end

  AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_evt |=> (vec_q == $past(wdata))); // R3
  AST_VEC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_evt |=> $stable(vec_q)); // R3
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |-> (rdata == 8'h00)); // R9
  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> (rdata == 8'h00)); // R10
endmodule

// File: tb/sim_sio_regfile.sv
module sim_sio_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  wire  [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_regfile u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // Behavioural reference model
  int         m_ptr [2];
  int         m_line[2];
  bit         m_full[2];
  int         m_byte[2];
  bit         m_ovr [2];
  int         m_vec;

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_ptr[c] = 0; m_line[c] = 0; m_full[c] = 0; m_byte[c] = 0; m_ovr[c] = 0;
    end
    m_vec = 0;
  endtask

  function automatic int model_read(bit r, bit w, int a);
    int ch;
    int v;
    if (!r || w || a < 252 || a > 255) return 0;
    ch = (a / 2) % 2;
    if (a % 2 == 0) return m_full[ch] ? m_byte[ch] : 0;
    v = 0;
    if (m_ptr[ch] == 0) begin
      if ((m_line[ch] / 2) % 2 == 1)   v += 32;
      if ((m_line[ch] / 128) % 2 == 1) v += 8;
      v += m_full[ch] ? 1 : 4;
    end else if (m_ptr[ch] == 1) begin
      v = m_ovr[ch] ? 32 : 0;
    end else if (m_ptr[ch] == 2) begin
      v = (ch == 1) ? m_vec : 0;
    end
    return v;
  endfunction

  task automatic model_step(bit r, bit w, int a, int d);
    int ch;
    int p;
    if (a < 252 || a > 255) return;
    ch = (a / 2) % 2;
    if (w) begin
      if (a % 2 == 0) begin
        if (m_full[ch]) m_ovr[ch] = 1;
        m_byte[ch] = d;
        m_full[ch] = 1;
      end else begin
        p = m_ptr[ch];
        if (p == 0) m_ptr[ch] = d % 8;
        else begin
          m_ptr[ch] = 0;
          if (p == 5) m_line[ch] = d;
          if (p == 1) m_ovr[ch] = 0;
          if (p == 2 && ch == 1) m_vec = d;
        end
      end
    end else if (r) begin
      if (a % 2 == 0) m_full[ch] = 0;
      else m_ptr[ch] = 0;
    end
  endtask

  task automatic op(bit r, bit w, int a, int d, string tag);
    int exp;
    @(negedge clk);
    rd_en = r; wr_en = w; addr = 8'(a); wdata = 8'(d);
    #4;
    exp = model_read(r, w, a);
    checks++;
    if (int'(rdata) != exp) begin
      errors++;
      $display("FAIL %s addr=%02h rd=%0d wr=%0d actual=%02h expected=%02h",
               tag, a, r, w, rdata, exp);
    end
    @(posedge clk);
    if (rst_n) model_step(r, w, a, d);
  endtask

  task automatic expect_val(int a, int exp, string tag);
    int got;
    @(negedge clk);
    rd_en = 1; wr_en = 0; addr = 8'(a); wdata = 8'h00;
    #4;
    got = int'(rdata);
    checks++;
    if (got != exp || got != model_read(1, 0, a)) begin
      errors++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", tag, a, got, exp);
    end
    @(posedge clk);
    model_step(1, 0, a, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    expect_val(8'hFD, 8'h04, "R8 status0 ch0");
    op(0, 1, 8'hFF, 8'h01, "R8 ptr");
    expect_val(8'hFF, 8'h00, "R8 overrun clear ch1");
    op(0, 1, 8'hFF, 8'h02, "R8 ptr");
    expect_val(8'hFF, 8'h00, "R8 vector clear");

    // R7: loopback data
    expect_val(8'hFC, 8'h00, "R7 empty read");
    op(0, 1, 8'hFC, 8'hA5, "R7 write");
    expect_val(8'hFD, 8'h01, "R7 status held");
    expect_val(8'hFC, 8'hA5, "R7 read back");
    expect_val(8'hFC, 8'h00, "R7 drained");

    // R5: overrun
    op(0, 1, 8'hFC, 8'h11, "R5 first");
    op(0, 1, 8'hFC, 8'h22, "R5 second");
    op(0, 1, 8'hFD, 8'h01, "R5 ptr1");
    expect_val(8'hFD, 8'h20, "R5 overrun flag");
    expect_val(8'hFC, 8'h22, "R5 newest byte kept");

    // R6: sticky overrun
    op(0, 1, 8'hFC, 8'h33, "R6 traffic");
    op(1, 0, 8'hFC, 0, "R6 traffic");
    op(0, 1, 8'hFD, 8'h01, "R6 ptr1");
    expect_val(8'hFD, 8'h20, "R6 still set");
    op(0, 1, 8'hFD, 8'h01, "R6 ptr1");
    op(0, 1, 8'hFD, 8'h00, "R6 clear write");
    op(0, 1, 8'hFD, 8'h01, "R6 ptr1");
    expect_val(8'hFD, 8'h00, "R6 cleared");

    // R4: status 0 line bits
    op(0, 1, 8'hFF, 8'h05, "R4 ptr5");
    op(0, 1, 8'hFF, 8'h82, "R4 line");
    expect_val(8'hFF, 8'h2C, "R4 status0 all line bits");
    op(0, 1, 8'hFF, 8'h05, "R4 ptr5");
    op(0, 1, 8'hFF, 8'h80, "R4 line");
    op(0, 1, 8'hFE, 8'h44, "R4 data");
    expect_val(8'hFF, 8'h09, "R4 status0 bit3 and held");

    // R2: pointer auto-clear
    op(0, 1, 8'hFF, 8'h01, "R2 ptr1");
    op(1, 0, 8'hFF, 0, "R2 read clears");
    expect_val(8'hFF, 8'h09, "R2 back to status0");

    // R3: vector
    op(0, 1, 8'hFF, 8'h02, "R3 ptr2");
    op(0, 1, 8'hFF, 8'h9A, "R3 load");
    op(0, 1, 8'hFF, 8'h02, "R3 ptr2");
    expect_val(8'hFF, 8'h9A, "R3 vector ch1");
    op(0, 1, 8'hFD, 8'h02, "R3 ptr2 ch0");
    expect_val(8'hFD, 8'h00, "R3 ch0 reads zero");
    op(0, 1, 8'hFD, 8'h02, "R3 ptr2 ch0");
    op(0, 1, 8'hFD, 8'h55, "R3 ch0 write");
    op(0, 1, 8'hFF, 8'h02, "R3 ptr2");
    expect_val(8'hFF, 8'h9A, "R3 ch0 write leaves vector");

    // R1: channel independence
    expect_val(8'hFC, 8'h00, "R1 ch0 empty");
    expect_val(8'hFE, 8'h44, "R1 ch1 byte");

    // R9: quiet bus and unused decode
    op(0, 1, 8'hFB, 8'h77, "R9 miss write");
    op(0, 1, 8'h7C, 8'h77, "R9 miss write");
    expect_val(8'hFC, 8'h00, "R9 miss write ignored");
    expect_val(8'h10, 8'h00, "R9 miss read");
    op(0, 1, 8'hFD, 8'h06, "R9 ptr6");
    expect_val(8'hFD, 8'h00, "R9 ptr6 read zero");
    op(0, 0, 8'hFC, 0, "R9 idle");

    // R10: both strobes
    op(1, 1, 8'hFC, 8'h77, "R10 both");
    expect_val(8'hFC, 8'h77, "R10 write done");

    // Random phase against model
    for (int i = 0; i < 4000; i++) begin
      int a;
      int sel;
      bit r;
      bit w;
      sel = $urandom_range(0, 15);
      a = (sel < 14) ? 252 + (sel % 4) : $urandom_range(0, 255);
      r = ($urandom_range(0, 2) != 0);
      w = ($urandom_range(0, 3) == 0) ? 1'b1 : ~r;
      op(r, w, a, $urandom_range(0, 255), "RANDOM");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule